// File: doc/BRIEF.md
# Voltage Regulator Start-Up Sequencer

This block is the digital start-up controller of a voltage regulator. Once the supply is good and the enable request is high, it waits a mode-dependent start delay. It then produces a DAC reference code that rises in timed steps. It also drives an active-low clock-enable output and a power-good output. A 1 µs timebase strobe paces every step of the ramp. A strobe once per PWM cycle, together with a comparator flag that shows the output is within tolerance, paces the qualification stage.

In CPU mode the reference rises slowly to a fixed boot code. The sequencer then waits until the output has stayed inside its window for a set number of consecutive PWM cycles. After that it lowers clock-enable and slews at the fast rate to the programmed target. In GPU mode there is no boot stage: after its shorter delay the reference climbs at the fast rate straight to the target, then goes through the same qualification. Once tracking, the reference follows target changes in either direction at the fast rate. Power-good rises once the sequencer is tracking and a fixed number of microseconds has passed since the start. Losing the supply or the enable request sends everything back to idle at the next clock.

Top module: `vr_startup_seq`

## Requirements
- R1: While `supply_ok` or `enable_req` is low, and after reset, `dac_code` is 0, `clk_en_n` is 1 and `pgood` is 0.
- R2: After a start, `dac_code` stays 0 for `DLY_CPU_US` (CPU, `gpu_mode`=0) or `DLY_GPU_US` (GPU, `gpu_mode`=1) `us_tick` pulses. The mode is sampled on the start clock.
- R3: In CPU mode, `dac_code` then rises by exactly 1 per `us_tick` and stops at `BOOT_CODE` without exceeding it.
- R4: Qualification needs `QUAL_CYC` `pwm_tick` pulses that all see `in_window` high. Any cycle with `in_window` low restarts the count, and `dac_code` holds during qualification.
- R5: `clk_en_n` falls on the clock edge at which qualification completes, and stays low until an abort.
- R6: While tracking, `dac_code` moves toward `vid_code` by 2 per `us_tick`, up or down, and lands exactly on the target when the remaining gap is 1.
- R7: In GPU mode, after the delay, `dac_code` rises by 2 per `us_tick` straight to `vid_code` (clamped), with no boot stop, then qualifies.
- R8: `pgood` is 1 only while tracking, starting one clock after at least `PG_DLY_US` `us_tick` pulses have been counted since the start.
- R9: Dropping `supply_ok` or `enable_req` in any state gives `dac_code`=0, `clk_en_n`=1, `pgood`=0 at the next clock edge, and a later start runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Controller supply above its reset threshold |
| enable_req | input | 1 | Regulator enable request |
| gpu_mode | input | 1 | 0: CPU sequence with boot stage; 1: GPU sequence |
| vid_code | input | CODE_W | Programmed target code (2.5 mV per LSB) |
| us_tick | input | 1 | One-clock strobe every microsecond |
| pwm_tick | input | 1 | One-clock strobe per PWM cycle |
| in_window | input | 1 | Output within tolerance of the present level |
| dac_code | output | CODE_W | Reference DAC code |
| clk_en_n | output | 1 | Active-low clock enable |
| pgood | output | 1 | Power good |

## Verification
The hardest situation to reach is a qualification that is broken part-way and then restarted, while the microsecond and PWM strobes run at unrelated rates. The bench drops `in_window` after a number of strobes short of the full count, then raises it again, so that only an unbroken run of strobes releases clock-enable. Aborts are placed in the delay, boot-ramp and tracking stages. Target steps are chosen with odd gaps so the final clamped step is exercised in both directions.

// File: rtl/vrss_pkg.sv
package vrss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_RAMP,
    ST_QUAL,
    ST_TRACK
  } seq_state_t;
endpackage

// File: rtl/vrss_tick_ctr.sv
// Saturating event counter, cleared synchronously.
module vrss_tick_ctr #(
  parameter int LIMIT = 1000,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  AST_CTR_SAT: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP); // R8
endmodule

// File: rtl/vrss_qual.sv
// Counts PWM strobes seen with the window flag high; any low cycle restarts.
module vrss_qual #(
  parameter int N = 13,
  localparam int QW = $clog2(N + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pwm_tick,
  input  logic in_window,
  output logic done
);
  localparam logic [QW-1:0] LAST = QW'(N - 1);
  logic [QW-1:0] qcnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !in_window) qcnt <= '0;
    else if (pwm_tick && qcnt != LAST) qcnt <= qcnt + 1'b1;
  end

  always_comb done = !clr && in_window && pwm_tick && (qcnt == LAST);

  AST_QCNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !in_window |=> qcnt == '0); // R4
endmodule

// File: rtl/vrss_slew.sv
// Reference register that steps toward a target by at most `step` per enable.
module vrss_slew #(
  parameter int CODE_W   = 11,
  parameter int STEP_MAX = 2,
  localparam int SW = $clog2(STEP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step_en,
  input  logic [CODE_W-1:0] target,
  input  logic [SW-1:0]     step,
  output logic [CODE_W-1:0] dac
);
  logic [CODE_W-1:0] gap, mv, step_x;
  logic              going_up;

  always_comb begin
    going_up = dac < target;
    gap      = going_up ? (target - dac) : (dac - target);
    step_x   = CODE_W'(step);
    mv       = (gap > step_x) ? step_x : gap;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) dac <= '0;
    else if (step_en) dac <= going_up ? (dac + mv) : (dac - mv);
  end

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    !clr && $past(!clr) && dac > $past(dac) |-> (dac - $past(dac)) <= CODE_W'(STEP_MAX)); // R6
  AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (rst)
    !clr && dac <= target |=> dac <= $past(target)); // R3
  AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (rst)
    !clr && dac >= target |=> (dac >= $past(target) || dac == '0)); // R6
endmodule

// File: rtl/vr_startup_seq.sv
module vr_startup_seq #(
  parameter int CODE_W     = 11,
  parameter int BOOT_CODE  = 440,
  parameter int DLY_CPU_US = 800,
  parameter int DLY_GPU_US = 120,
  parameter int PG_DLY_US  = 7000,
  parameter int QUAL_CYC   = 13,
  parameter int SLOW_STEP  = 1,
  parameter int FAST_STEP  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              enable_req,
  input  logic              gpu_mode,
  input  logic [CODE_W-1:0] vid_code,
  input  logic              us_tick,
  input  logic              pwm_tick,
  input  logic              in_window,
  output logic [CODE_W-1:0] dac_code,
  output logic              clk_en_n,
  output logic              pgood
);
  import vrss_pkg::*;

  localparam int DLY_MAX  = (DLY_CPU_US > DLY_GPU_US) ? DLY_CPU_US : DLY_GPU_US;
  localparam int DW       = $clog2(DLY_MAX + 1);
  localparam int PW       = $clog2(PG_DLY_US + 1);
  localparam int STEP_MAX = (FAST_STEP > SLOW_STEP) ? FAST_STEP : SLOW_STEP;
  localparam int SW       = $clog2(STEP_MAX + 1);
  localparam logic [CODE_W-1:0] BOOT_C   = CODE_W'(BOOT_CODE);
  localparam logic [DW-1:0]     LAST_CPU = DW'(DLY_CPU_US - 1);
  localparam logic [DW-1:0]     LAST_GPU = DW'(DLY_GPU_US - 1);
  localparam logic [PW-1:0]     PG_LIM   = PW'(PG_DLY_US);

  seq_state_t state, nxt;
  logic              gpu_lat;
  logic              run;
  logic [DW-1:0]     dly_cnt, dly_last;
  logic [PW-1:0]     pg_cnt;
  logic              dly_hit, qual_done, pg_done;
  logic              slew_clr, slew_en, boot_phase;
  logic [CODE_W-1:0] slew_tgt;
  logic [SW-1:0]     slew_step;

  always_comb begin
    run        = supply_ok && enable_req;
    dly_last   = gpu_lat ? LAST_GPU : LAST_CPU;
    dly_hit    = us_tick && (dly_cnt == dly_last);
    boot_phase = (state == ST_RAMP) && !gpu_lat;
    slew_tgt   = boot_phase ? BOOT_C : vid_code;
    slew_step  = boot_phase ? SW'(SLOW_STEP) : SW'(FAST_STEP);
    slew_en    = us_tick && (state == ST_RAMP || state == ST_TRACK);
    slew_clr   = !run || (state == ST_IDLE);
    pg_done    = pg_cnt >= PG_LIM;
  end

  always_comb begin
    nxt = state;
    if (!run) nxt = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE:  nxt = ST_DELAY;
        ST_DELAY: if (dly_hit) nxt = ST_RAMP;
        ST_RAMP:  if (dac_code == slew_tgt) nxt = ST_QUAL;
        ST_QUAL:  if (qual_done) nxt = ST_TRACK;
        ST_TRACK: nxt = ST_TRACK;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      gpu_lat  <= 1'b0;
      clk_en_n <= 1'b1;
      pgood    <= 1'b0;
    end else begin
      state    <= nxt;
      if (state == ST_IDLE) gpu_lat <= gpu_mode;
      clk_en_n <= (nxt != ST_TRACK);
      pgood    <= run && (state == ST_TRACK) && pg_done;
    end
  end

  vrss_tick_ctr #(.LIMIT(DLY_MAX)) u_dly (
    .clk(clk), .rst(rst), .clr(state != ST_DELAY || !run),
    .inc(us_tick), .cnt(dly_cnt));

  vrss_tick_ctr #(.LIMIT(PG_DLY_US)) u_pg (
    .clk(clk), .rst(rst), .clr(state == ST_IDLE || !run),
    .inc(us_tick), .cnt(pg_cnt));

  vrss_qual #(.N(QUAL_CYC)) u_qual (
    .clk(clk), .rst(rst), .clr(state != ST_QUAL || !run),
    .pwm_tick(pwm_tick), .in_window(in_window), .done(qual_done));

  vrss_slew #(.CODE_W(CODE_W), .STEP_MAX(STEP_MAX)) u_slew (
    .clk(clk), .rst(rst), .clr(slew_clr), .step_en(slew_en),
    .target(slew_tgt), .step(slew_step), .dac(dac_code));

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> dac_code == '0 && clk_en_n && !pgood); // R9
  AST_PG_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    pgood |-> !clk_en_n); // R8
  AST_CE_ONLY_TRACK: assert property (@(posedge clk) disable iff (rst)
    !clk_en_n |-> state == ST_TRACK); // R5
  AST_BOOT_CAP: assert property (@(posedge clk) disable iff (rst)
    state == ST_RAMP && !gpu_lat |-> dac_code <= BOOT_C); // R3
  AST_DELAY_ZERO: assert property (@(posedge clk) disable iff (rst)
    state == ST_DELAY |-> dac_code == '0); // R2
  AST_QUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    state == ST_QUAL && $past(state) == ST_QUAL |-> $stable(dac_code)); // R4
endmodule

// File: tb/vr_startup_seq_bench.sv
module vr_startup_seq_bench;
  localparam int CW   = 11;
  localparam int BOOT = 40;
  localparam int DCPU = 20;
  localparam int DGPU = 6;
  localparam int PGD  = 150;
  localparam int QN   = 13;

  logic clk = 1'b0, rst = 1'b1;
  logic supply_ok = 1'b0, enable_req = 1'b0, gpu_mode = 1'b0;
  logic [CW-1:0] vid_code = '0;
  logic us_tick = 1'b0, pwm_tick = 1'b0, in_window = 1'b0;
  logic [CW-1:0] dac_code;
  logic clk_en_n, pgood;

  int n_chk = 0, n_bad = 0;
  int us_div = 0, pwm_div = 0;

  always #5 clk = ~clk;

  vr_startup_seq #(.CODE_W(CW), .BOOT_CODE(BOOT), .DLY_CPU_US(DCPU),
    .DLY_GPU_US(DGPU), .PG_DLY_US(PGD), .QUAL_CYC(QN)) u_vr_startup_seq (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .enable_req(enable_req),
    .gpu_mode(gpu_mode), .vid_code(vid_code), .us_tick(us_tick),
    .pwm_tick(pwm_tick), .in_window(in_window), .dac_code(dac_code),
    .clk_en_n(clk_en_n), .pgood(pgood));

  // strobes: us every 4 clocks, pwm every 3 clocks
  always @(negedge clk) begin
    us_div  = (us_div + 1) % 4;
    pwm_div = (pwm_div + 1) % 3;
    us_tick  <= (us_div == 0);
    pwm_tick <= (pwm_div == 0);
  end

  // behavioural reference model
  int m_st = 0, m_dac = 0, m_q = 0, m_dly = 0, m_pgc = 0;
  bit m_ce = 1, m_pg = 0, m_gpu = 0;

  function automatic int toward(int d, int t, int s);
    if (d < t) return d + ((t - d) < s ? (t - d) : s);
    return d - ((d - t) < s ? (d - t) : s);
  endfunction

  always @(posedge clk) begin
    bit npg;
    int tgt;
    if (rst) begin
      m_st = 0; m_dac = 0; m_ce = 1; m_pg = 0; m_pgc = 0; m_q = 0; m_dly = 0;
    end else if (!(supply_ok && enable_req)) begin
      m_st = 0; m_dac = 0; m_ce = 1; m_pg = 0; m_pgc = 0; m_q = 0; m_dly = 0;
    end else begin
      npg = (m_st == 4) && (m_pgc >= PGD);
      if (m_st == 0) m_pgc = 0;
      else if (us_tick && m_pgc < PGD) m_pgc++;
      case (m_st)
        0: begin m_st = 1; m_gpu = gpu_mode; m_dly = 0; end
        1: if (us_tick) begin
             if (m_dly == (m_gpu ? DGPU : DCPU) - 1) m_st = 2; else m_dly++;
           end
        2: begin
             tgt = m_gpu ? int'(vid_code) : BOOT;
             m_q = 0;
             if (m_dac == tgt) m_st = 3;
             else if (us_tick) m_dac = toward(m_dac, tgt, m_gpu ? 2 : 1);
           end
        3: if (!in_window) m_q = 0;
           else if (pwm_tick) begin
             if (m_q == QN - 1) m_st = 4; else m_q++;
           end
        default: if (us_tick) m_dac = toward(m_dac, int'(vid_code), 2);
      endcase
      m_ce = (m_st != 4);
      m_pg = npg;
    end
  end

  function automatic string st_tag(int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(int'(dac_code) == m_dac, st_tag(m_st), "dac_code", int'(dac_code), m_dac);
      check(clk_en_n == m_ce, "R5", "clk_en_n", int'(clk_en_n), int'(m_ce));
      check(pgood == m_pg, "R8", "pgood", int'(pgood), int'(m_pg));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_dac(int v, int lim);
    for (int i = 0; i < lim && int'(dac_code) != v; i++) @(negedge clk);
  endtask

  task automatic wait_ce_low(int lim);
    for (int i = 0; i < lim && clk_en_n; i++) @(negedge clk);
  endtask

  task automatic wait_pwm_strobes(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!pwm_tick) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cyc(100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int peak;
    cyc(4);
    check(dac_code == 0 && clk_en_n && !pgood, "R1", "reset outputs", int'(dac_code), 0);
    rst = 1'b0;

    // R1: enable without supply, then supply without enable
    enable_req = 1'b1; cyc(60);
    check(dac_code == 0 && clk_en_n, "R1", "no supply idle", int'(dac_code), 0);
    enable_req = 1'b0; supply_ok = 1'b1; cyc(60);
    check(dac_code == 0 && clk_en_n && !pgood, "R1", "no enable idle", int'(dac_code), 0);

    // CPU run
    vid_code = 11'd101; gpu_mode = 1'b0; in_window = 1'b0;
    enable_req = 1'b1;
    cyc(3); gpu_mode = 1'b1;      // ignored after start (R2)
    cyc(4 * (DCPU - 2));
    check(dac_code == 0, "R2", "dac held in cpu delay", int'(dac_code), 0);
    peak = 0;
    for (int i = 0; i < 400 && int'(dac_code) != BOOT; i++) begin
      @(negedge clk);
      if (int'(dac_code) > peak) peak = int'(dac_code);
    end
    check(int'(dac_code) == BOOT, "R3", "boot code reached", int'(dac_code), BOOT);
    gpu_mode = 1'b0;
    cyc(80);
    check(int'(dac_code) == BOOT && clk_en_n, "R3", "boot plateau held", int'(dac_code), BOOT);
    // R4: broken qualification
    in_window = 1'b1;
    wait_pwm_strobes(QN - 3);
    in_window = 1'b0; cyc(2); in_window = 1'b1;
    wait_pwm_strobes(QN - 2);
    check(clk_en_n == 1'b1, "R4", "count restarted after window drop", int'(clk_en_n), 1);
    wait_ce_low(200);
    check(clk_en_n == 1'b0, "R5", "clock enable low after qualify", int'(clk_en_n), 0);
    wait_dac(101, 400);
    check(int'(dac_code) == 101, "R6", "odd target reached", int'(dac_code), 101);
    for (int i = 0; i < 2000 && !pgood; i++) @(negedge clk);
    check(pgood == 1'b1, "R8", "power good after timer", int'(pgood), 1);
    vid_code = 11'd30; wait_dac(30, 400);
    check(int'(dac_code) == 30, "R6", "downward slew", int'(dac_code), 30);
    vid_code = 11'd37; wait_dac(37, 100);
    check(int'(dac_code) == 37, "R6", "upward odd step", int'(dac_code), 37);

    // R9: abort in tracking
    enable_req = 1'b0; cyc(1);
    check(dac_code == 0 && clk_en_n && !pgood, "R9", "abort from tracking", int'(dac_code), 0);
    // R9: abort in delay and in boot ramp
    cyc(5); enable_req = 1'b1; cyc(30); supply_ok = 1'b0; cyc(1);
    check(dac_code == 0 && clk_en_n, "R9", "abort from delay", int'(dac_code), 0);
    supply_ok = 1'b1; cyc(4 * DCPU + 60);
    check(dac_code != 0, "R9", "restart ramps again", int'(dac_code), 1);
    enable_req = 1'b0; cyc(1);
    check(dac_code == 0, "R9", "abort from ramp", int'(dac_code), 0);

    // GPU run
    cyc(5); gpu_mode = 1'b1; vid_code = 11'd61; in_window = 1'b0;
    enable_req = 1'b1; cyc(3); gpu_mode = 1'b0;
    cyc(4 * (DGPU - 2));
    check(dac_code == 0, "R2", "dac held in gpu delay", int'(dac_code), 0);
    wait_dac(2, 40);
    check(int'(dac_code) == 2, "R7", "first gpu step is 2", int'(dac_code), 2);
    wait_dac(61, 400); cyc(20);
    check(int'(dac_code) == 61 && clk_en_n, "R7", "gpu goes past boot to target", int'(dac_code), 61);
    in_window = 1'b1; wait_ce_low(200);
    check(clk_en_n == 1'b0, "R7", "gpu qualifies", int'(clk_en_n), 0);
    check(pgood == 1'b0, "R8", "pgood waits for timer", int'(pgood), 0);
    for (int i = 0; i < 2000 && !pgood; i++) @(negedge clk);
    check(pgood == 1'b1, "R8", "gpu power good", int'(pgood), 1);
    cyc(10);
    finish_run();
  end
endmodule